// File: doc/BRIEF.md
# Command-Driven Buffer Access Port

This block gives a host processor a narrow path into an on-chip descriptor buffer. The host writes one opcode byte on a command strobe and then moves 16-bit words on data strobes. Every opcode picks a target. It can select a burst into the buffer or a burst out of it. It can also select one of a few small control registers: the transfer length, the slot size, the end-of-transfer flag and the burst status.

Before a burst, the host loads a byte count. A buffer opcode clears an internal byte pointer. Each data access then moves one word and advances the pointer by two bytes. The burst closes on the access that brings the pointer to or beyond the count. At that point a sticky end-of-transfer interrupt is raised and a status bit records which direction finished.

A slot-size register splits the buffer into equal slots. A registered multiplier turns a slot index into the byte address where that slot starts. The buffer is an inferred single-port RAM with a registered read.

Top module: `xbp_top`

## Requirements
- R1: After reset, `rdata` is 0, `eot_irq` is 0, the transfer count reads 0, the status reads 0 and the slot size reads 64. `slot_base` is 0 during reset and equals `slot_idx*64` one cycle later.
- R2: Opcode 0xC3 opens a write burst and opcode 0x43 opens a read burst. Each data access in the burst moves one 16-bit word at word address (byte pointer / 2) modulo `BUF_WORDS`, then adds 2 to the byte pointer.
- R3: Each buffer opcode (0x43 or 0xC3) resets the byte pointer to 0 and clears both done bits of the status register, even in the middle of a burst.
- R4: The transfer count is written with opcode 0xA2 and read with 0x22; it takes all 16 data bits. A burst ends on the access where pointer+2 >= count, so an odd count ends on its last word. With a count of 0 the burst ends as soon as the opcode is taken. Once a burst has ended, data writes leave the buffer unchanged and data reads return 0.
- R5: `eot_irq` becomes 1 in the cycle after a burst ends and then stays 1. The host clears it by selecting opcode 0xA4 and making a data write with bit 0 = 1; a write with bit 0 = 0 leaves it set. Opcode 0x24 reads it back in bit 0.
- R6: Opcode 0x2C reads the status register. Bit 0 is set when a write burst has ended, bit 1 is set when a read burst has ended, and every other bit reads 0.
- R7: The slot size is written with opcode 0xD3 and read with 0x53. A write keeps data bits 9:3 and forces bits 2:0 to zero. Bits 15:10 are ignored on write and read as 0. A stored value of 0 means 1024 bytes.
- R8: `slot_base` equals `slot_idx` times the effective slot size, one clock after either input changes.
- R9: `rdata` carries the result of a data read from the cycle after the read and holds it until the next read. After an unknown opcode, reads return 0 and writes have no effect.
- R10: When strobes coincide, `cmd_wr` wins over both data strobes, and `dat_wr` wins over `dat_rd`. A losing strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Opcode strobe; the opcode is `wdata[7:0]` |
| dat_wr | input | 1 | Data write strobe |
| dat_rd | input | 1 | Data read strobe |
| wdata | input | 16 | Opcode or write data |
| rdata | output | 16 | Read data, valid the cycle after `dat_rd` |
| eot_irq | output | 1 | Sticky end-of-transfer interrupt |
| slot_idx | input | SLOT_W | Slot index to convert |
| slot_base | output | SLOT_W+11 | Byte address where the slot starts |

## Verification
The bench builds the port with `BUF_WORDS=16`, `CNT_W=16` and `SLOT_W=4`. A 16-word buffer lets a 36-byte burst run past the end and wrap onto words 0 and 1, so the modulo addressing is checked by values that come back on later reads. The 4-bit slot index together with slot sizes of 64, 288 and 1024 covers both the encoding of 0 as 1024 bytes and the widest product the output must carry. A behavioural model is compared on every clock while random strobes cover cases the directed part does not reach: coinciding strobes, unknown opcodes, and bursts cut short by a new opcode.

// File: rtl/xbp_pkg.sv
package xbp_pkg;

  localparam int DATA_W = 16;
  localparam int OP_W   = 8;
  localparam int BLK_W  = 10;

  localparam logic [OP_W-1:0] OP_BUF_RD = 8'h43;
  localparam logic [OP_W-1:0] OP_BUF_WR = 8'hC3;
  localparam logic [OP_W-1:0] OP_BLK_RD = 8'h53;
  localparam logic [OP_W-1:0] OP_BLK_WR = 8'hD3;
  localparam logic [OP_W-1:0] OP_CNT_RD = 8'h22;
  localparam logic [OP_W-1:0] OP_CNT_WR = 8'hA2;
  localparam logic [OP_W-1:0] OP_IRQ_RD = 8'h24;
  localparam logic [OP_W-1:0] OP_IRQ_WR = 8'hA4;
  localparam logic [OP_W-1:0] OP_STS_RD = 8'h2C;

  localparam logic [BLK_W-1:0] BLK_RESET = 10'd64;

  typedef enum logic [3:0] {
    MODE_IDLE,
    MODE_BUF_RD,
    MODE_BUF_WR,
    MODE_BLK_RD,
    MODE_BLK_WR,
    MODE_CNT_RD,
    MODE_CNT_WR,
    MODE_IRQ_RD,
    MODE_IRQ_WR,
    MODE_STS_RD
  } port_mode_e;

  function automatic port_mode_e decode_op(input logic [OP_W-1:0] op);
    port_mode_e m;
    case (op)
      OP_BUF_RD: m = MODE_BUF_RD;
      OP_BUF_WR: m = MODE_BUF_WR;
      OP_BLK_RD: m = MODE_BLK_RD;
      OP_BLK_WR: m = MODE_BLK_WR;
      OP_CNT_RD: m = MODE_CNT_RD;
      OP_CNT_WR: m = MODE_CNT_WR;
      OP_IRQ_RD: m = MODE_IRQ_RD;
      OP_IRQ_WR: m = MODE_IRQ_WR;
      OP_STS_RD: m = MODE_STS_RD;
      default:   m = MODE_IDLE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/xbp_ram.sv
module xbp_ram #(
  parameter int WORDS = 1024,
  parameter int DW    = 16,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= din;
    if (re) dout <= mem[addr];
  end

  AST_NO_RW_CLASH: assert property (@(posedge clk) !(we && re)); // R10

endmodule

// File: rtl/xbp_slot.sv
module xbp_slot #(
  parameter int SLOT_W = 5,
  parameter int BLK_W  = 10,
  localparam int OUT_W = SLOT_W + BLK_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [BLK_W-1:0]  blk_field,
  output logic [OUT_W-1:0]  slot_base
);

  logic [BLK_W:0] eff_size;

  always_comb begin
    if (blk_field == '0) eff_size = {1'b1, {BLK_W{1'b0}}};
    else                 eff_size = {1'b0, blk_field};
  end

  always_ff @(posedge clk) begin
    if (rst) slot_base <= '0;
    else     slot_base <= OUT_W'(slot_idx) * OUT_W'(eff_size);
  end

  AST_SLOT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    slot_base[2:0] == 3'b000); // R8

endmodule

// File: rtl/xbp_ctrl.sv
module xbp_ctrl
  import xbp_pkg::*;
#(
  parameter int WORDS = 1024,
  parameter int CNT_W = 16,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [DATA_W-1:0] wdata,
  output logic              ram_we,
  output logic              ram_re,
  output logic [AW-1:0]     ram_addr,
  output logic [DATA_W-1:0] ram_din,
  output logic              sel_buf,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              eot_irq,
  output logic [BLK_W-1:0]  blk_field
);

  port_mode_e         mode_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   ptr_q;
  logic [BLK_W-1:0]   blk_q;
  logic               irq_q;
  logic               wdone_q;
  logic               rdone_q;
  logic               sel_q;
  logic [DATA_W-1:0]  rd_q;

  logic               take_cmd;
  logic               take_wr;
  logic               take_rd;
  logic               buf_wr_go;
  logic               buf_rd_go;
  logic               buf_step;
  logic               buf_op;
  logic               op_is_wr;
  logic [CNT_W:0]     ptr_nx;
  logic               last_beat;
  logic [DATA_W-1:0]  reg_mux;

  // strobe priority: opcode, then write, then read
  assign take_cmd  = cmd_wr;
  assign take_wr   = dat_wr & ~cmd_wr;
  assign take_rd   = dat_rd & ~cmd_wr & ~dat_wr;

  assign buf_wr_go = take_wr && (mode_q == MODE_BUF_WR);
  assign buf_rd_go = take_rd && (mode_q == MODE_BUF_RD);
  assign buf_step  = buf_wr_go | buf_rd_go;

  assign buf_op    = (wdata[OP_W-1:0] == OP_BUF_RD) || (wdata[OP_W-1:0] == OP_BUF_WR);
  assign op_is_wr  = (wdata[OP_W-1:0] == OP_BUF_WR);

  assign ptr_nx    = {1'b0, ptr_q} + (CNT_W+1)'(2);
  assign last_beat = ptr_nx >= {1'b0, cnt_q};

  assign ram_we    = buf_wr_go;
  assign ram_re    = buf_rd_go;
  assign ram_addr  = ptr_q[AW:1];
  assign ram_din   = wdata;

  always_comb begin
    case (mode_q)
      MODE_CNT_RD: reg_mux = DATA_W'(cnt_q);
      MODE_BLK_RD: reg_mux = DATA_W'(blk_q);
      MODE_IRQ_RD: reg_mux = DATA_W'(irq_q);
      MODE_STS_RD: reg_mux = DATA_W'({rdone_q, wdone_q});
      default:     reg_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_IDLE;
      cnt_q   <= '0;
      ptr_q   <= '0;
      blk_q   <= BLK_RESET;
      irq_q   <= 1'b0;
      wdone_q <= 1'b0;
      rdone_q <= 1'b0;
      sel_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      if (take_cmd) begin
        mode_q <= decode_op(wdata[OP_W-1:0]);
        if (buf_op) begin
          ptr_q   <= '0;
          wdone_q <= 1'b0;
          rdone_q <= 1'b0;
          if (cnt_q == '0) begin
            mode_q <= MODE_IDLE;
            irq_q  <= 1'b1;
            if (op_is_wr) wdone_q <= 1'b1;
            else          rdone_q <= 1'b1;
          end
        end
      end

      if (buf_step) begin
        ptr_q <= ptr_nx[CNT_W-1:0];
        if (last_beat) begin
          mode_q <= MODE_IDLE;
          irq_q  <= 1'b1;
          if (buf_wr_go) wdone_q <= 1'b1;
          else           rdone_q <= 1'b1;
        end
      end

      if (take_wr) begin
        case (mode_q)
          MODE_CNT_WR: cnt_q <= CNT_W'(wdata);
          MODE_BLK_WR: blk_q <= {wdata[BLK_W-1:3], 3'b000};
          MODE_IRQ_WR: if (wdata[0]) irq_q <= 1'b0;
          default: ;
        endcase
      end

      if (take_rd) begin
        sel_q <= buf_rd_go;
        rd_q  <= reg_mux;
      end
    end
  end

  assign sel_buf   = sel_q;
  assign reg_rdata = rd_q;
  assign eot_irq   = irq_q;
  assign blk_field = blk_q;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    buf_step |=> (ptr_q == $past(ptr_q) + CNT_W'(2))); // R2

  AST_CMD_PTR_CLR: assert property (@(posedge clk) disable iff (rst)
    (take_cmd && buf_op) |=> (ptr_q == '0)); // R3

  AST_EOT_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (buf_step && last_beat) |=> (eot_irq && mode_q == MODE_IDLE)); // R4

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !(take_wr && mode_q == MODE_IRQ_WR && wdata[0])) |=> irq_q); // R5

  AST_BLK_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    blk_q[2:0] == 3'b000); // R7

  AST_CMD_WINS: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && dat_wr && mode_q == MODE_CNT_WR) |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/xbp_top.sv
module xbp_top
  import xbp_pkg::*;
#(
  parameter int BUF_WORDS = 1024,
  parameter int CNT_W     = 16,
  parameter int SLOT_W    = 5,
  localparam int AW       = $clog2(BUF_WORDS),
  localparam int BASE_W   = SLOT_W + BLK_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              eot_irq,
  input  logic [SLOT_W-1:0] slot_idx,
  output logic [BASE_W-1:0] slot_base
);

  logic              ram_we;
  logic              ram_re;
  logic [AW-1:0]     ram_addr;
  logic [DATA_W-1:0] ram_din;
  logic [DATA_W-1:0] ram_dout;
  logic              sel_buf;
  logic [DATA_W-1:0] reg_rdata;
  logic [BLK_W-1:0]  blk_field;

  xbp_ctrl #(
    .WORDS (BUF_WORDS),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .dat_wr    (dat_wr),
    .dat_rd    (dat_rd),
    .wdata     (wdata),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_addr  (ram_addr),
    .ram_din   (ram_din),
    .sel_buf   (sel_buf),
    .reg_rdata (reg_rdata),
    .eot_irq   (eot_irq),
    .blk_field (blk_field)
  );

  xbp_ram #(
    .WORDS (BUF_WORDS),
    .DW    (DATA_W)
  ) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .re   (ram_re),
    .addr (ram_addr),
    .din  (ram_din),
    .dout (ram_dout)
  );

  xbp_slot #(
    .SLOT_W (SLOT_W),
    .BLK_W  (BLK_W)
  ) u_slot (
    .clk       (clk),
    .rst       (rst),
    .slot_idx  (slot_idx),
    .blk_field (blk_field),
    .slot_base (slot_base)
  );

  // both sources are registers; the select is registered with them
  assign rdata = sel_buf ? ram_dout : reg_rdata;

endmodule

// File: tb/xbp_top_bench.sv
module xbp_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BW         = 16;
  localparam int SW         = 4;
  localparam int BASE_W     = SW + 11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_wr = 1'b0;
  logic              dat_wr = 1'b0;
  logic              dat_rd = 1'b0;
  logic [15:0]       wdata = '0;
  logic [15:0]       rdata;
  logic              eot_irq;
  logic [SW-1:0]     slot_idx = '0;
  logic [BASE_W-1:0] slot_base;

  int n_chk  = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbp_top #(
    .BUF_WORDS (BW),
    .CNT_W     (16),
    .SLOT_W    (SW)
  ) u_xbp_top (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .dat_wr    (dat_wr),
    .dat_rd    (dat_rd),
    .wdata     (wdata),
    .rdata     (rdata),
    .eot_irq   (eot_irq),
    .slot_idx  (slot_idx),
    .slot_base (slot_base)
  );

  // ---------------- behavioural reference model ----------------
  int m_cmd, m_ptr, m_cnt, m_blk, m_rd, m_slot;
  bit m_live, m_irq, m_wd, m_rdn;
  int m_mem [BW];

  task automatic m_finish(input bit was_wr);
    m_ptr += 2;
    if (m_ptr >= m_cnt) begin
      m_live = 0;
      m_irq  = 1;
      if (was_wr) m_wd = 1; else m_rdn = 1;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cmd = 0; m_ptr = 0; m_cnt = 0; m_blk = 64; m_rd = 0; m_slot = 0;
      m_live = 0; m_irq = 0; m_wd = 0; m_rdn = 0;
    end else begin
      m_slot = int'(slot_idx) * ((m_blk == 0) ? 1024 : m_blk);
      if (cmd_wr) begin
        m_cmd = int'(wdata[7:0]);
        if (m_cmd == 'h43 || m_cmd == 'hC3) begin
          m_ptr = 0; m_wd = 0; m_rdn = 0;
          if (m_cnt == 0) begin
            m_live = 0; m_irq = 1;
            if (m_cmd == 'hC3) m_wd = 1; else m_rdn = 1;
          end else m_live = 1;
        end else m_live = 0;
      end else if (dat_wr) begin
        case (m_cmd)
          'hC3: if (m_live) begin
                  m_mem[(m_ptr/2) % BW] = int'(wdata);
                  m_finish(1);
                end
          'hA2: m_cnt = int'(wdata);
          'hD3: m_blk = int'(wdata) & 'h3F8;
          'hA4: if (wdata[0]) m_irq = 0;
          default: ;
        endcase
      end else if (dat_rd) begin
        case (m_cmd)
          'h43: if (m_live) begin
                  m_rd = m_mem[(m_ptr/2) % BW];
                  m_finish(0);
                end else m_rd = 0;
          'h22: m_rd = m_cnt;
          'h53: m_rd = m_blk;
          'h24: m_rd = int'(m_irq);
          'h2C: m_rd = int'(m_rdn) * 2 + int'(m_wd);
          default: m_rd = 0;
        endcase
      end
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (cmp_on) begin
      check(int'(rdata), m_rd, "R9 rdata vs model");
      check(int'(eot_irq), int'(m_irq), "R5 eot_irq vs model");
      check(int'(slot_base), m_slot, "R8 slot_base vs model");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulse(input bit c, input bit w, input bit r, input logic [15:0] d);
    cmd_wr = c; dat_wr = w; dat_rd = r; wdata = d;
    @(negedge clk);
    cmd_wr = 0; dat_wr = 0; dat_rd = 0;
  endtask

  task automatic op(input logic [7:0] code);
    pulse(1, 0, 0, {8'h00, code});
  endtask

  task automatic wr(input logic [15:0] d);
    pulse(0, 1, 0, d);
  endtask

  task automatic rd_expect(input int exp, input string tag);
    pulse(0, 0, 1, 16'h0000);
    check(int'(rdata), exp, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(int'(rdata), 0, "R1 rdata in reset");
    check(int'(eot_irq), 0, "R1 eot_irq in reset");
    check(int'(slot_base), 0, "R1 slot_base in reset");
    rst = 1'b0;
    cmp_on = 1'b1;

    // reset values
    op(8'h53); rd_expect(64, "R1 R7 slot size default");
    op(8'h22); rd_expect(0, "R1 count default");
    op(8'h2C); rd_expect(0, "R1 R6 status default");
    slot_idx = 4'd3; @(negedge clk);
    check(int'(slot_base), 192, "R1 R8 slot base 3x64");

    // slot size encoding
    op(8'hD3); wr(16'hFD23);
    op(8'h53); rd_expect('h120, "R7 truncate low bits, drop high bits");
    check(int'(slot_base), 3 * 'h120, "R8 slot base 3x288");
    op(8'hD3); wr(16'hFC00);
    op(8'h53); rd_expect(0, "R7 zero field read back");
    check(int'(slot_base), 3 * 1024, "R7 R8 zero means 1024");
    slot_idx = 4'd15; @(negedge clk);
    check(int'(slot_base), 15 * 1024, "R8 widest product");

    // wrap: 36 bytes into a 16-word buffer
    op(8'hA2); wr(16'd36);
    op(8'hC3);
    for (int i = 0; i < 18; i++) wr(16'h1000 + 16'(i));
    check(int'(eot_irq), 1, "R4 R5 eot after 36 bytes");
    op(8'h43);
    for (int i = 0; i < 18; i++) begin
      int j;
      j = i % BW;
      rd_expect('h1000 + ((j < 2) ? j + 16 : j), "R2 wrap read back");
    end
    op(8'hA4); wr(16'h0001);
    check(int'(eot_irq), 0, "R5 cleared by write 1");

    // odd count: 5 bytes closes on the third word
    op(8'hA2); wr(16'd5);
    op(8'hC3);
    wr(16'hAAAA); wr(16'hBBBB);
    check(int'(eot_irq), 0, "R4 not yet at count");
    wr(16'hCCCC);
    check(int'(eot_irq), 1, "R4 odd count ends on last word");
    wr(16'hDDDD);
    op(8'h2C); rd_expect(1, "R6 write done bit");
    op(8'h43);
    rd_expect('hAAAA, "R2 word 0");
    rd_expect('hBBBB, "R2 word 1");
    rd_expect('hCCCC, "R2 word 2");
    rd_expect(0, "R4 read after end returns 0");
    op(8'h2C); rd_expect(2, "R3 R6 read done, write bit cleared");
    op(8'hA2); wr(16'd8);
    op(8'h43);
    for (int i = 0; i < 3; i++) pulse(0, 0, 1, 16'h0);
    rd_expect('h1003, "R4 write after end left word 3");

    // sticky interrupt and clear rule
    op(8'hA4); wr(16'h0000);
    check(int'(eot_irq), 1, "R5 write 0 keeps flag");
    op(8'h24); rd_expect(1, "R5 flag readback");
    op(8'hA4); wr(16'hFFFF);
    check(int'(eot_irq), 0, "R5 write 1 clears");

    // zero count
    op(8'hA2); wr(16'd0);
    op(8'hC3);
    check(int'(eot_irq), 1, "R4 zero count ends at opcode");
    op(8'hA4); wr(16'h0001);

    // restart mid-burst
    op(8'hA2); wr(16'd8);
    op(8'hC3); wr(16'h7777);
    op(8'hC3);
    op(8'h2C); rd_expect(0, "R3 status cleared by opcode");
    op(8'hC3); wr(16'h8888);
    op(8'h43); rd_expect('h8888, "R3 pointer restarted at word 0");

    // strobe priority
    op(8'hA2);
    pulse(1, 1, 0, 16'h0022);
    rd_expect(8, "R10 opcode beat data write");
    repeat (3) @(negedge clk);
    check(int'(rdata), 8, "R9 rdata holds between reads");
    op(8'hA2);
    pulse(0, 1, 1, 16'h0010);
    check(int'(rdata), 8, "R10 read lost to write");
    op(8'h22); rd_expect('h10, "R10 write taken");

    // unknown opcode
    op(8'h55); wr(16'h1234);
    rd_expect(0, "R9 unknown opcode reads 0");
    op(8'h22); rd_expect('h10, "R9 unknown opcode write ignored");

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int k;
      logic [7:0] codes [10];
      codes = '{8'h43, 8'hC3, 8'h53, 8'hD3, 8'h22, 8'hA2, 8'h24, 8'hA4, 8'h2C, 8'h55};
      k = $urandom_range(0, 9);
      slot_idx = SW'($urandom);
      if ($urandom_range(0, 5) == 0)
        pulse(1, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, {8'h00, codes[k]});
      else
        pulse(0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
              ($urandom_range(0, 1) == 1) ? 16'($urandom_range(0, 40)) : 16'($urandom));
    end

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule